// File: doc/BRIEF.md
# Runtime-Configurable Grey-Level Morphology Filter

This block sits behind a sliding-window extractor in a pixel pipeline. Each clock it may receive one square neighbourhood of up to 7x7 grey-level pixels and turns it into one output pixel. Three operations are available. Erosion takes the darkest pixel under the structuring element. Dilation takes the brightest. The gradient is the difference between the two, computed from the same neighbourhood.

The structuring element is chosen while the block runs. It can be a plus-shaped cross, a full square, or an arbitrary bit pattern that software supplies. The element is clipped to a kernel of 3x3, 5x5 or 7x7. An optional final stage turns the result into a two-level image by comparing it against a programmable threshold.

Configuration arrives on plain ports. It is captured only on the window that marks the start of a frame, so one frame is always processed with one setting. Opening and closing are made by cascading two instances with a second window extractor between them.

Top module: `morph_filter`

## Requirements
- R1: With operation code 0 (erode), the output is the minimum of the window pixels whose cells are enabled.
- R2: With operation code 1 (dilate), the output is the maximum of the enabled window pixels.
- R3: With operation code 2 or 3 (gradient), the output is the dilate result minus the erode result for the same window. It is 0 when no cell is enabled.
- R4: Cell r*7+c holds the pixel at row r, column c, with the centre at (3,3). The pixel occupies bits [8*(r*7+c)+7 : 8*(r*7+c)] of the window bus. Shape code 0 enables cells on row 3 or column 3. Shape code 1 enables every cell. Shape codes 2 and 3 enable the cells whose bit is set in the custom mask, where mask bit index equals cell index.
- R5: Size code 0 keeps only cells with |r-3|<=1 and |c-3|<=1. Size code 1 uses a bound of 2. Size codes 2 and 3 use a bound of 3. A cell is enabled only if it is inside this bound and also selected by the shape.
- R6: Disabled cells never influence the result. Erode over an empty element gives 255, and dilate gives 0.
- R7: When binarization is enabled, the output is 255 if the selected result is greater than or equal to the threshold, and 0 otherwise. When it is disabled, the result passes unchanged.
- R8: The operation, shape, size, custom mask, binarize enable and threshold are captured on a valid window flagged as start of frame, and that window already uses them. Changes on these inputs at any other time have no effect until the next start-of-frame window.
- R9: Every valid window produces exactly one valid output, 8 clock cycles after the edge that accepts it. No output is valid in any other cycle. Results keep their input order.
- R10: While reset is held, and after it is released until the first result emerges, the output valid signal is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| winValid | input | 1 | A window is present this cycle |
| winSof | input | 1 | The present window is the first of a frame |
| winPix | input | 392 | 49 pixels of 8 bits, cell r*7+c at bit 8*(r*7+c) |
| cfgOp | input | 2 | 0 erode, 1 dilate, 2/3 gradient |
| cfgShape | input | 2 | 0 cross, 1 square, 2/3 custom mask |
| cfgSize | input | 2 | 0 3x3, 1 5x5, 2/3 7x7 |
| cfgMask | input | 49 | Custom structuring element, one bit per cell |
| cfgBinEn | input | 1 | Enables the threshold stage |
| cfgThresh | input | 8 | Binarization threshold |
| outValid | output | 1 | Output pixel is valid |
| outPix | output | 8 | Filtered pixel |

## Verification
A frame boundary with a new setting can coincide with windows of the previous frame that are still in the reduction pipeline. That collision is the one that matters. The bench streams frames back to back, mostly with no bubble between them, over every operation, shape, size and binarize combination. It scrambles every configuration input on the cycles that are not frame starts. Each output is judged against a value computed arithmetically from the setting captured for its own frame. The output must also arrive exactly eight cycles after its window. A setting that leaked forward or backward across the boundary, or a result taken from the wrong slot, shows up as a mismatch on the first windows of each frame.

// File: rtl/mf_pkg.sv
package mf_pkg;

  typedef enum logic [1:0] {
    OP_ERODE  = 2'd0,
    OP_DILATE = 2'd1,
    OP_GRAD   = 2'd2
  } mfOp_e;

  typedef struct packed {
    logic  go;
    mfOp_e op;
    logic  binEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/mf_ctrl.sv
module mf_ctrl
  import mf_pkg::*;
#(
  parameter int WIN   = 7,
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  winValid,
  input  logic                  winSof,
  input  logic [1:0]            cfgOp,
  input  logic [1:0]            cfgShape,
  input  logic [1:0]            cfgSize,
  input  logic [WIN*WIN-1:0]    cfgMask,
  input  logic                  cfgBinEn,
  input  logic [PIX_W-1:0]      cfgThresh,
  output ctrlStrobe_t           strobe,
  output logic [WIN*WIN-1:0]    enMask,
  output logic [PIX_W-1:0]      threshOut
);
  localparam int CELLS = WIN * WIN;
  localparam int CTR   = WIN / 2;

  logic               takeCfg;
  mfOp_e              heldOp, effOp;
  logic [1:0]         heldShape, effShape, heldSize, effSize;
  logic [CELLS-1:0]   heldMask, effMask;
  logic               heldBin, effBin;
  logic [PIX_W-1:0]   heldTh;
  int                 half;
  int                 side;

  function automatic mfOp_e decodeOp(input logic [1:0] code);
    case (code)
      2'd0:    return OP_ERODE;
      2'd1:    return OP_DILATE;
      default: return OP_GRAD;
    endcase
  endfunction

  assign takeCfg = winValid && winSof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldOp    <= OP_ERODE;
      heldShape <= 2'd1;
      heldSize  <= 2'd0;
      heldMask  <= '0;
      heldBin   <= 1'b0;
      heldTh    <= '0;
    end else if (takeCfg) begin
      heldOp    <= decodeOp(cfgOp);
      heldShape <= cfgShape;
      heldSize  <= cfgSize;
      heldMask  <= cfgMask;
      heldBin   <= cfgBinEn;
      heldTh    <= cfgThresh;
    end
  end

  // the start-of-frame window already uses its own setting
  assign effOp     = takeCfg ? decodeOp(cfgOp) : heldOp;
  assign effShape  = takeCfg ? cfgShape : heldShape;
  assign effSize   = takeCfg ? cfgSize : heldSize;
  assign effMask   = takeCfg ? cfgMask : heldMask;
  assign effBin    = takeCfg ? cfgBinEn : heldBin;
  assign threshOut = takeCfg ? cfgThresh : heldTh;

  always_comb begin
    case (effSize)
      2'd0:    half = 1;
      2'd1:    half = 2;
      default: half = 3;
    endcase
    if (half > CTR) half = CTR;
    side = 2 * half + 1;
  end

  always_comb begin
    enMask = '0;
    for (int r = 0; r < WIN; r++) begin
      for (int c = 0; c < WIN; c++) begin
        logic inWin, shapeBit;
        inWin = ((r > CTR) ? (r - CTR) : (CTR - r)) <= half &&
                ((c > CTR) ? (c - CTR) : (CTR - c)) <= half;
        case (effShape)
          2'd0:    shapeBit = (r == CTR) || (c == CTR);
          2'd1:    shapeBit = 1'b1;
          default: shapeBit = effMask[r*WIN+c];
        endcase
        enMask[r*WIN+c] = inWin && shapeBit;
      end
    end
  end

  assign strobe.go    = winValid;
  assign strobe.op    = effOp;
  assign strobe.binEn = effBin;

  // R5: never more cells than the selected kernel holds
  p_mask_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    winValid |-> $countones(enMask) <= side * side);

  // R4: the cross occupies one row and one column of the kernel
  p_cross_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (winValid && effShape == 2'd0) |-> $countones(enMask) == 2 * side - 1);

  // R8: setting only moves on a start-of-frame window
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !takeCfg |=> ($stable(heldOp) && $stable(heldMask) && $stable(heldSize) &&
                  $stable(heldShape) && $stable(heldBin) && $stable(heldTh)));
endmodule

// File: rtl/mf_datapath.sv
module mf_datapath
  import mf_pkg::*;
#(
  parameter int WIN   = 7,
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobe_t              strobe,
  input  logic [WIN*WIN-1:0]       enMask,
  input  logic [PIX_W-1:0]         thresh,
  input  logic [WIN*WIN*PIX_W-1:0] winPix,
  output logic                     outValid,
  output logic [PIX_W-1:0]         outPix
);
  localparam int CELLS  = WIN * WIN;
  localparam int LEVELS = $clog2(CELLS);
  localparam int NPAD   = 1 << LEVELS;
  localparam logic [PIX_W-1:0] FULL = '1;

  // heap layout: node 1 is the root, leaves sit at NPAD .. 2*NPAD-1
  logic [PIX_W-1:0] mnNode [1:2*NPAD-1];
  logic [PIX_W-1:0] mxNode [1:2*NPAD-1];

  logic             vldP [0:LEVELS];
  logic             anyP [0:LEVELS];
  mfOp_e            opP  [0:LEVELS];
  logic             binP [0:LEVELS];
  logic [PIX_W-1:0] thP  [0:LEVELS];

  logic [PIX_W-1:0] selRes, finalRes;
  logic             outBin;

  always_ff @(posedge clk) begin
    for (int j = 0; j < CELLS; j++) begin
      mnNode[NPAD+j] <= enMask[j] ? winPix[j*PIX_W +: PIX_W] : FULL;
      mxNode[NPAD+j] <= enMask[j] ? winPix[j*PIX_W +: PIX_W] : '0;
    end
    for (int j = CELLS; j < NPAD; j++) begin
      mnNode[NPAD+j] <= FULL;
      mxNode[NPAD+j] <= '0;
    end
    for (int k = 1; k < NPAD; k++) begin
      mnNode[k] <= (mnNode[2*k] < mnNode[2*k+1]) ? mnNode[2*k] : mnNode[2*k+1];
      mxNode[k] <= (mxNode[2*k] > mxNode[2*k+1]) ? mxNode[2*k] : mxNode[2*k+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= LEVELS; s++) vldP[s] <= 1'b0;
    end else begin
      vldP[0] <= strobe.go;
      for (int s = 1; s <= LEVELS; s++) vldP[s] <= vldP[s-1];
    end
  end

  always_ff @(posedge clk) begin
    anyP[0] <= |enMask;
    opP[0]  <= strobe.op;
    binP[0] <= strobe.binEn;
    thP[0]  <= thresh;
    for (int s = 1; s <= LEVELS; s++) begin
      anyP[s] <= anyP[s-1];
      opP[s]  <= opP[s-1];
      binP[s] <= binP[s-1];
      thP[s]  <= thP[s-1];
    end
  end

  always_comb begin
    case (opP[LEVELS])
      OP_ERODE:  selRes = mnNode[1];
      OP_DILATE: selRes = mxNode[1];
      default:   selRes = (mxNode[1] >= mnNode[1]) ? mxNode[1] - mnNode[1] : '0;
    endcase
    if (binP[LEVELS]) finalRes = (selRes >= thP[LEVELS]) ? FULL : '0;
    else              finalRes = selRes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outPix   <= '0;
      outBin   <= 1'b0;
    end else begin
      outValid <= vldP[LEVELS];
      outBin   <= binP[LEVELS];
      if (vldP[LEVELS]) outPix <= finalRes;
    end
  end

  // R1 R2: the two trees agree whenever any cell is enabled
  p_min_le_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vldP[LEVELS] && anyP[LEVELS]) |-> mnNode[1] <= mxNode[1]);

  // R6: an empty element leaves the fill values at the root
  p_empty_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vldP[LEVELS] && !anyP[LEVELS]) |-> (mnNode[1] == FULL && mxNode[1] == '0));

  // R7: a binarized output has only two levels
  p_bin_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outBin) |-> (outPix == '0 || outPix == FULL));
endmodule

// File: rtl/morph_filter.sv
module morph_filter
  import mf_pkg::*;
#(
  parameter int WIN   = 7,
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     winValid,
  input  logic                     winSof,
  input  logic [WIN*WIN*PIX_W-1:0] winPix,
  input  logic [1:0]               cfgOp,
  input  logic [1:0]               cfgShape,
  input  logic [1:0]               cfgSize,
  input  logic [WIN*WIN-1:0]       cfgMask,
  input  logic                     cfgBinEn,
  input  logic [PIX_W-1:0]         cfgThresh,
  output logic                     outValid,
  output logic [PIX_W-1:0]         outPix
);
  localparam int CELLS = WIN * WIN;
  localparam int LAT   = $clog2(CELLS) + 2;
  localparam int CW    = $clog2(LAT + 2) + 1;

  ctrlStrobe_t      strobe;
  logic [CELLS-1:0] enMask;
  logic [PIX_W-1:0] threshSel;
  logic [CW-1:0]    inFlight;

  mf_ctrl #(.WIN(WIN), .PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .winValid(winValid), .winSof(winSof),
    .cfgOp(cfgOp), .cfgShape(cfgShape), .cfgSize(cfgSize), .cfgMask(cfgMask),
    .cfgBinEn(cfgBinEn), .cfgThresh(cfgThresh),
    .strobe(strobe), .enMask(enMask), .threshOut(threshSel)
  );

  mf_datapath #(.WIN(WIN), .PIX_W(PIX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .enMask(enMask),
    .thresh(threshSel), .winPix(winPix),
    .outValid(outValid), .outPix(outPix)
  );

  // windows accepted but not yet delivered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inFlight <= '0;
    else        inFlight <= inFlight + CW'(winValid) - CW'(outValid);
  end

  // R9: no result without an accepted window
  p_no_orphan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> inFlight != '0);

  // R9: occupancy is bounded by the fixed latency
  p_inflight_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inFlight <= CW'(LAT));
endmodule

// File: tb/morph_filter_tb.sv
module morph_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 7;
  localparam int PIX_W = 8;
  localparam int CELLS = WIN * WIN;
  localparam int LAT   = 8;
  localparam int QD    = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic winValid = 1'b0, winSof = 1'b0;
  logic [CELLS*PIX_W-1:0] winPix = '0;
  logic [1:0] cfgOp = '0, cfgShape = '0, cfgSize = '0;
  logic [CELLS-1:0] cfgMask = '0;
  logic cfgBinEn = 1'b0;
  logic [PIX_W-1:0] cfgThresh = '0;
  logic outValid;
  logic [PIX_W-1:0] outPix;

  int nCmp = 0, nBad = 0, cyc = 0, wr = 0, rd = 0;
  bit done = 0;
  int expPix [0:QD-1];
  int expT   [0:QD-1];
  int expOp  [0:QD-1];
  int expBin [0:QD-1];

  // frame setting as the model sees it
  int fOp, fShape, fSize, fBin, fTh;
  logic [CELLS-1:0] fMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  morph_filter #(.WIN(WIN), .PIX_W(PIX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .winValid(winValid), .winSof(winSof), .winPix(winPix),
    .cfgOp(cfgOp), .cfgShape(cfgShape), .cfgSize(cfgSize), .cfgMask(cfgMask),
    .cfgBinEn(cfgBinEn), .cfgThresh(cfgThresh), .outValid(outValid), .outPix(outPix)
  );

  function automatic string tagOf(int op, int bin);
    string s;
    s = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
    if (bin != 0) s = {s, " R7"};
    return {s, " (R4 R5 R6 R8 setting)"};
  endfunction

  // expected result from the requirement formulas
  function automatic int model(logic [CELLS*PIX_W-1:0] pix);
    int mn = 255, mx = 0, h, res;
    bit any = 0;
    h = (fSize == 0) ? 1 : (fSize == 1) ? 2 : 3;
    for (int r = 0; r < WIN; r++)
      for (int c = 0; c < WIN; c++) begin
        int dr = (r > 3) ? r - 3 : 3 - r;
        int dc = (c > 3) ? c - 3 : 3 - c;
        bit sel = (fShape == 0) ? (r == 3 || c == 3) : (fShape == 1) ? 1'b1 : fMask[r*WIN+c];
        if (dr <= h && dc <= h && sel) begin
          int v = int'(pix[(r*WIN+c)*PIX_W +: PIX_W]);
          any = 1;
          if (v < mn) mn = v;
          if (v > mx) mx = v;
        end
      end
    if (fOp == 0) res = mn;
    else if (fOp == 1) res = mx;
    else res = any ? mx - mn : 0;
    if (fBin != 0) res = (res >= fTh) ? 255 : 0;
    return res;
  endfunction

  task automatic checkOut();
    if (outValid) begin
      nCmp++;
      if (rd == wr) begin
        nBad++;
        $display("FAIL R9 cycle %0d: unexpected valid output %0d, expected none", cyc, outPix);
      end else begin
        if (expT[rd % QD] != cyc) begin
          nBad++;
          $display("FAIL R9: output at cycle %0d, expected cycle %0d", cyc, expT[rd % QD]);
        end
        nCmp++;
        if (int'(outPix) != expPix[rd % QD]) begin
          nBad++;
          $display("FAIL %s: got %0d expected %0d (item %0d)",
                   tagOf(expOp[rd % QD], expBin[rd % QD]), outPix, expPix[rd % QD], rd);
        end
        rd++;
      end
    end else if (rd != wr && expT[rd % QD] <= cyc) begin
      nCmp++; nBad++;
      $display("FAIL R9: no output at cycle %0d, expected value %0d", cyc, expPix[rd % QD]);
      rd++;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    checkOut();
  endtask

  task automatic scramble();
    cfgOp = 2'($urandom); cfgShape = 2'($urandom); cfgSize = 2'($urandom);
    cfgMask = {$urandom, $urandom}; cfgBinEn = 1'($urandom); cfgThresh = 8'($urandom);
  endtask

  task automatic sendWin(bit sof, int style);
    winValid = 1'b1;
    winSof = sof;
    for (int j = 0; j < CELLS; j++)
      winPix[j*PIX_W +: PIX_W] = (style == 0) ? 8'($urandom) : 8'(100 + $urandom % 4);
    if (!sof) scramble();  // R8: ignored mid-frame
    expPix[wr % QD] = model(winPix);
    expT[wr % QD]   = cyc + LAT;
    expOp[wr % QD]  = fOp;
    expBin[wr % QD] = fBin;
    wr++;
  endtask

  initial begin
    int fr = 0;
    // R10: output idle during and after reset
    repeat (3) begin
      step();
      nCmp++;
      if (outValid !== 1'b0) begin
        nBad++;
        $display("FAIL R10: outValid=%b during reset, expected 0", outValid);
      end
    end
    rst_n = 1'b1;
    for (int op = 0; op < 4; op++)
      for (int sh = 0; sh < 4; sh++)
        for (int sz = 0; sz < 4; sz++)
          for (int bn = 0; bn < 2; bn++) begin
            step();
            fOp = (op > 2) ? 2 : op; fShape = sh; fSize = sz; fBin = bn;
            fTh = (fr % 5 == 0) ? 0 : int'($urandom % 256);
            case (fr % 3)
              0: fMask = '0;
              1: fMask = '1;
              default: fMask = {$urandom, $urandom};
            endcase
            cfgOp = 2'(op); cfgShape = 2'(sh); cfgSize = 2'(sz); cfgBinEn = bn[0];
            cfgThresh = 8'(fTh); cfgMask = fMask;
            sendWin(1'b1, fr % 2);
            for (int w = 0; w < 5; w++) begin
              step();
              if (w == 2 && fr % 4 == 1) begin
                winValid = 1'b0; winSof = 1'b1; scramble();  // bubble, R8 ignored
                step();
              end
              sendWin(1'b0, w % 2);
            end
            fr++;
          end
    step();
    winValid = 1'b0; winSof = 1'b0;
    repeat (LAT + 4) step();
    nCmp++;
    if (rd != wr) begin
      nBad++;
      $display("FAIL R9: %0d results delivered, expected %0d", rd, wr);
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule